// File: doc/BRIEF.md
# Host Source Line Aligner

This block sits between a host-fed 32-bit word stream and a block-transfer engine. It turns the incoming words into a per-pixel stream for a rectangle that is `lineWidth` pixels wide and `lineCount` lines tall. Each output pixel is marked when it closes a line. Three source layouts are handled:

- **Packed monochrome:** one bit per pixel, with lines following one another inside the same words.
- **Unpacked monochrome:** one bit per pixel, with every line starting in a word of its own.
- **Color:** one byte per pixel, with every line starting in a word of its own.

A job starts with a one-cycle `start` pulse, which captures the configuration. The start point inside the first word comes from `byteOfs`, a byte lane from 0 to 3. In the two monochrome layouts, `bitSkip` then moves the start 0 to 7 bits further. The block holds a word at its input until every bit it needs from that word has been used or deliberately thrown away. Only then does it take the word, by raising `inReady` in the cycle its own output is accepted.

The block stops once the last pixel of the last line has been accepted. It drops whatever is left of that word and pulses `done`. Word arrival and pixel acceptance are both flow-controlled. No word is ever dropped or taken early.

Top module: `srcLineAligner`

## Requirements
- R1: After reset, and whenever no job is running, `outValid`, `inReady` and `done` are low.
- R2: In the monochrome layouts (mode 0 packed, modes 1 and 3 unpacked), the first pixel of a line is found as follows. Within a byte, bits count from bit 7 down to bit 0. The first pixel is the bit at count position `bitSkip` inside byte lane `byteOfs` of the word. Byte lane n covers word bits 8n+7..8n. The pixel is presented on `outPix[0]`, and `outPix[7:1]` is zero.
- R3: In color mode (mode 2), the first pixel of a line is byte lane `byteOfs`, and `bitSkip` has no effect.
- R4: Within a line, monochrome pixels advance one bit at a time, from bit 7 down to bit 0 of a byte, with byte lanes in ascending order. Color pixels advance one byte lane at a time, in ascending order. When a line runs past lane 3, it continues at lane 0 of the next word.
- R5: In packed mode, after the last pixel of a line, the block drops the unused bits of that byte and then `bitSkip` more bits. The next line starts there, in the same word if the position is still inside it.
- R6: In unpacked and color modes, after the last pixel of a line, the rest of the word is discarded and the word is taken. The next line starts in the next word, at the R2/R3 start point.
- R7: `outEol` is high exactly on the `lineWidth`-th pixel of every line. `lineWidth` and `lineCount` are at least 1.
- R8: While `outReady` is low, no word is taken, and the presented pixel and the input word stay unchanged.
- R9: `done` pulses for one cycle, in the cycle after the last pixel of the last line is accepted. That final word is taken even if it still has unused bits, and no further word is taken.
- R10: A `start` pulse while a job is running is ignored, and so are changes to the configuration inputs during the job.
- R11: `inReady` is high only in a cycle where a pixel is accepted and that pixel uses up the current word, through a wrap, a discard or the end of the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle job start; captures the configuration |
| mode | input | 2 | 0 packed mono, 1 or 3 unpacked mono, 2 color (8 bits/pixel) |
| byteOfs | input | 2 | Starting byte lane within a word |
| bitSkip | input | 3 | Mono starting bit within the byte; also the packed inter-line skip |
| lineWidth | input | WW | Pixels per line (at least 1) |
| lineCount | input | LW | Lines per job (at least 1) |
| inData | input | 32 | Source word |
| inValid | input | 1 | Source word present |
| inReady | output | 1 | Source word taken this cycle |
| outPix | output | 8 | Pixel: the mono bit in bit 0, or the color byte |
| outValid | output | 1 | Pixel present |
| outReady | input | 1 | Pixel accepted by the consumer |
| outEol | output | 1 | Pixel is the last of its line |
| done | output | 1 | One-cycle pulse after the final pixel |

## Verification
The bench runs the following input patterns:

- **Packed and unpacked, same settings:** both monochrome layouts run with byte lane 0, a two-bit skip and eight-pixel lines. With these settings, packed lines start 16 bits apart within one word, while unpacked lines each start at the same place in fresh words. This pair separates the skip rule from the discard rule.
- **Packed with the largest offsets:** a run with byte lane 3 and a seven-bit skip makes lines straddle word boundaries. This exposes wrap and pop errors.
- **Wide unpacked lines:** lines wider than one word check that a line continues across words before the discard.
- **Color with a nonzero skip:** this shows that the skip is ignored and that bytes step in lane order.
- **Random output stalls and a second start mid-job:** these check that nothing is taken while the output is held and that the running job is unaffected.

// File: rtl/srcAlignPkg.sv
package srcAlignPkg;
  localparam int WORD_W = 32;
  localparam int POS_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    MODE_PACKED   = 2'd0,
    MODE_UNPACKED = 2'd1,
    MODE_COLOR    = 2'd2,
    MODE_UNPACK2  = 2'd3
  } srcMode_e;

  typedef struct packed {
    logic busy;      // job running
    logic load;      // capture configuration this cycle
    logic fire;      // output pixel accepted this cycle
    logic eol;       // current pixel closes its line
    logic lastLine;  // current line is the final one
  } ctlStrobes_t;
endpackage

// File: rtl/lineCtl.sv
module lineCtl
  import srcAlignPkg::*;
#(
  parameter int WW = 12,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          inValid,
  input  logic          outReady,
  input  logic [WW-1:0] lineWidth,
  input  logic [LW-1:0] lineCount,
  output ctlStrobes_t   ctl,
  output logic          outValid,
  output logic          outEol,
  output logic          done
);
  logic          busy;
  logic [WW-1:0] pixCnt, widthQ;
  logic [LW-1:0] lineIdx, countQ;
  logic          fire, eolNow, lastNow, load;

  assign load     = start && !busy;
  assign outValid = busy && inValid;
  assign fire     = outValid && outReady;
  assign eolNow   = busy && (pixCnt == widthQ - WW'(1));
  assign lastNow  = (lineIdx == countQ - LW'(1));
  assign outEol   = outValid && eolNow;

  always_comb begin
    ctl.busy     = busy;
    ctl.load     = load;
    ctl.fire     = fire;
    ctl.eol      = eolNow;
    ctl.lastLine = lastNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      pixCnt  <= '0;
      lineIdx <= '0;
      widthQ  <= '0;
      countQ  <= '0;
      done    <= 1'b0;
    end else begin
      done <= fire && eolNow && lastNow;
      if (load) begin
        busy    <= 1'b1;
        pixCnt  <= '0;
        lineIdx <= '0;
        widthQ  <= lineWidth;
        countQ  <= lineCount;
      end else if (fire) begin
        if (eolNow) begin
          pixCnt <= '0;
          if (lastNow) busy <= 1'b0;
          else         lineIdx <= lineIdx + LW'(1);
        end else begin
          pixCnt <= pixCnt + WW'(1);
        end
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid);
  assert_eol_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> pixCnt < widthQ);
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fire && eolNow && lastNow) |=> (done && !busy));
  assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !fire) |=> ($stable(pixCnt) && $stable(lineIdx) && $stable(widthQ)));
endmodule

// File: rtl/pixPath.sv
module pixPath
  import srcAlignPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [1:0]        mode,
  input  logic [1:0]        byteOfs,
  input  logic [2:0]        bitSkip,
  input  logic [WORD_W-1:0] inData,
  output logic [7:0]        outPix,
  output logic              inReady
);
  logic [POS_W-1:0] pos, startPos, nextPos;
  logic [POS_W:0]   stepCand, packEolCand, cand;
  logic [1:0]       modeQ;
  logic [1:0]       ofsQ;
  logic [2:0]       skipQ;
  logic             isColor, isPacked, popReq;

  assign isColor  = (modeQ == MODE_COLOR);
  assign isPacked = (modeQ == MODE_PACKED);
  assign startPos = {ofsQ, (isColor ? 3'd0 : skipQ)};

  // pos counts bits in consumption order: byte lane in [4:3], bit-from-MSB in [2:0]
  always_comb begin
    if (isColor) outPix = inData[{pos[4:3], 3'b000} +: 8];
    else         outPix = {7'd0, inData[{pos[4:3], ~pos[2:0]}]};
  end

  assign stepCand    = {1'b0, pos} + (isColor ? (POS_W+1)'(8) : (POS_W+1)'(1));
  assign packEolCand = {1'b0, pos[4:3], 3'b000} + (POS_W+1)'(8) + {3'd0, skipQ};
  assign cand        = (ctl.eol && isPacked) ? packEolCand : stepCand;

  always_comb begin
    if (ctl.eol && ctl.lastLine) popReq = 1'b1;
    else if (ctl.eol && !isPacked) popReq = 1'b1;
    else popReq = cand[POS_W];
    if (ctl.eol && !isPacked) nextPos = startPos;
    else nextPos = cand[POS_W-1:0];
  end

  assign inReady = ctl.fire && popReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos   <= '0;
      modeQ <= MODE_PACKED;
      ofsQ  <= '0;
      skipQ <= '0;
    end else if (ctl.load) begin
      modeQ <= mode;
      ofsQ  <= byteOfs;
      skipQ <= bitSkip;
      pos   <= {byteOfs, (mode == MODE_COLOR) ? 3'd0 : bitSkip};
    end else if (ctl.fire) begin
      pos <= nextPos;
    end
  end

  assert_pop_on_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> ctl.fire);
  assert_color_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && isColor) |-> (pos[2:0] == 3'd0));
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && !ctl.fire) |=> $stable(pos));
  assert_discard_pops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && ctl.eol && !isPacked) |-> inReady);
endmodule

// File: rtl/srcLineAligner.sv
module srcLineAligner
  import srcAlignPkg::*;
#(
  parameter int WW = 12,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [1:0]    byteOfs,
  input  logic [2:0]    bitSkip,
  input  logic [WW-1:0] lineWidth,
  input  logic [LW-1:0] lineCount,
  input  logic [31:0]   inData,
  input  logic          inValid,
  output logic          inReady,
  output logic [7:0]    outPix,
  output logic          outValid,
  input  logic          outReady,
  output logic          outEol,
  output logic          done
);
  ctlStrobes_t ctl;

  lineCtl #(.WW(WW), .LW(LW)) i_lineCtl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .outReady(outReady),
    .lineWidth(lineWidth), .lineCount(lineCount), .ctl(ctl),
    .outValid(outValid), .outEol(outEol), .done(done)
  );

  pixPath i_pixPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mode(mode), .byteOfs(byteOfs),
    .bitSkip(bitSkip), .inData(inData), .outPix(outPix), .inReady(inReady)
  );

  assert_stall_no_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> !inReady);
endmodule

// File: tb/test_srcLineAligner.sv
module test_srcLineAligner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  byteOfs = '0;
  logic [2:0]  bitSkip = '0;
  logic [11:0] lineWidth = 12'd1;
  logic [11:0] lineCount = 12'd1;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  outPix;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        outEol;
  logic        done;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] pix; logic eol; string req; } expItem_t;
  expItem_t expQ[$];
  logic [31:0] words[64];
  int  wIdx;
  int  needWords;
  int  lastItems;
  bit  pendDone;
  bit  stallEn;

  always #5 clk = ~clk;

  srcLineAligner i_srcLineAligner (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .byteOfs(byteOfs),
    .bitSkip(bitSkip), .lineWidth(lineWidth), .lineCount(lineCount),
    .inData(inData), .inValid(inValid), .inReady(inReady), .outPix(outPix),
    .outValid(outValid), .outReady(outReady), .outEol(outEol), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic monoBit(input int g);
    return words[g >> 5][8 * ((g >> 3) & 3) + 7 - (g & 7)];
  endfunction

  function automatic logic [7:0] colorByte(input int g);
    return words[g >> 5][8 * ((g >> 3) & 3) +: 8];
  endfunction

  // Scoreboard model built from R2..R7: global bit index over the word array
  task automatic buildExpect(input int md, input int ofs, input int sk,
                             input int w, input int lines, input string req);
    int g, lastG, wb;
    expItem_t it;
    g = 0; lastG = 0; wb = 0;
    if (md == 0) g = ofs * 8 + sk;
    for (int ln = 0; ln < lines; ln++) begin
      if (md != 0) g = wb * 32 + ofs * 8 + ((md == 2) ? 0 : sk);
      for (int i = 0; i < w; i++) begin
        it.pix = (md == 2) ? colorByte(g) : {7'd0, monoBit(g)};
        it.eol = (i == w - 1);
        it.req = req;
        expQ.push_back(it);
        lastG = g;
        g += (md == 2) ? 8 : 1;
      end
      if (md == 0) g = ((lastG >> 3) + 1) * 8 + sk;   // R5
      else wb = (lastG >> 5) + 1;                       // R6
    end
    needWords = (lastG >> 5) + 1;
  endtask

  // Monitor: samples settled values 1 ns after each falling edge
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (pendDone) begin
        check(done === 1'b1, "R9 done pulse", done, 1);
        check(outValid === 1'b0, "R9 idle after done", outValid, 0);
        pendDone = 1'b0;
      end else if (done !== 1'b0) begin
        check(1'b0, "R9 spurious done", done, 0);
      end
      if (!outReady && inReady) check(1'b0, "R8 pop while stalled", inReady, 0);
      if (inReady && !(outValid && outReady)) check(1'b0, "R11 pop without accept", inReady, 0);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 pixel after job", outPix, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(outPix === e.pix, e.req, outPix, e.pix);
          check(outEol === e.eol, "R7 end-of-line flag", outEol, e.eol);
          if (expQ.size() == 0) begin
            check(inReady === 1'b1, "R9 final word dropped", inReady, 1);
            pendDone = 1'b1;
          end
        end
      end
    end
  end

  // Driver: configure, push expectations, feed words, optional restart (R10)
  task automatic runJob(input int md, input int ofs, input int sk, input int w,
                        input int lines, input bit stall, input bit restart,
                        input string req);
    int cyc;
    logic [7:0] heldPix;
    bit held;
    for (int i = 0; i < 64; i++) words[i] = $urandom;
    buildExpect(md, ofs, sk, w, lines, req);
    wIdx = 0;
    stallEn = stall;
    @(negedge clk);
    mode = 2'(md); byteOfs = 2'(ofs); bitSkip = 3'(sk);
    lineWidth = 12'(w); lineCount = 12'(lines);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    held = 1'b0;
    heldPix = '0;
    while ((expQ.size() != 0 || pendDone) && cyc < 4000) begin
      inValid = (wIdx < needWords + 2);
      inData  = words[wIdx];
      outReady = stallEn ? ($urandom % 3 != 0) : 1'b1;
      if (restart && cyc == 4) begin
        start = 1'b1; mode = 2'd2; byteOfs = 2'd3; bitSkip = 3'd0;
        lineWidth = 12'd1; lineCount = 12'd1;
      end else begin
        start = 1'b0;
      end
      #2;
      if (held && outValid) check(outPix === heldPix, "R8 pixel held in stall", outPix, heldPix);
      held = outValid && !outReady;
      heldPix = outPix;
      if (inReady) wIdx++;
      cyc++;
      @(negedge clk);
      if (held && inData != words[wIdx]) check(1'b0, "R8 word changed", 0, 1);
    end
    start = 1'b0;
    inValid = 1'b0;
    outReady = 1'b1;
    check(cyc < 4000, "watchdog", cyc, 4000);
    check(wIdx == needWords, "R9 words taken", wIdx, needWords);
    expQ.delete();
    @(negedge clk);
  endtask

  initial begin
    pendDone = 1'b0;
    #1;
    check(outValid === 1'b0 && inReady === 1'b0 && done === 1'b0, "R1 reset outputs", outValid, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    #2;
    check(outValid === 1'b0 && inReady === 1'b0, "R1 idle with word present", inReady, 0);
    inValid = 1'b0;
    runJob(0, 0, 2, 8, 3, 1'b0, 1'b0, "R5 packed pixel");
    runJob(1, 0, 2, 8, 3, 1'b0, 1'b0, "R6 unpacked pixel");
    runJob(2, 1, 5, 3, 2, 1'b0, 1'b0, "R3 color pixel");
    runJob(0, 3, 7, 13, 4, 1'b1, 1'b0, "R2 packed straddling pixel");
    runJob(1, 2, 1, 40, 2, 1'b1, 1'b0, "R4 wide unpacked pixel");
    runJob(3, 1, 3, 5, 3, 1'b0, 1'b0, "R2 mode3 unpacked pixel");
    runJob(2, 0, 0, 9, 3, 1'b1, 1'b0, "R4 color span pixel");
    runJob(0, 1, 4, 1, 6, 1'b0, 1'b0, "R7 width1 packed pixel");
    runJob(0, 2, 3, 6, 4, 1'b0, 1'b1, "R10 restart ignored pixel");
    runJob(1, 3, 6, 2, 2, 1'b1, 1'b1, "R11 unpacked lane3 pixel");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule